// File: doc/BRIEF.md
# Converter Fault Supervisor with Auto-Restart

This block is the protection sequencer of a switching converter controller. Synchronous comparator flags come in: feedback high, ramp pin high and low, two supply overvoltage levels, supply under the off level, supply over the on level, over-temperature, soft start active and burst active. Each fault has its own qualification timer. When a fault has been present for its qualification time, the block latches an auto-restart state. In that state it holds the power switch off and records which fault caused the entry.

The overload path has two stages. First, the feedback-high flag must hold for a long internal window, and the block then releases the clamp on the external ramp pin. Second, once the ramp-high flag has held for a short spike filter, auto-restart is entered. The external shutdown input cuts the gate in the same cycle and qualifies into auto-restart, but it is masked for a short window after each start. All timers count a common microsecond tick and clear at once when their condition drops. The block leaves auto-restart only after the supply has dropped under the off level and then risen over the on level again. A new start, with soft start, follows.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is high and right after it, gate_stop is 1, clamp_rel is 0, ar_state is 0 and ar_cause is 0 (none).
- R2: From the reset idle state, supply_on high for one cycle starts the run state, and gate_stop is 0 from the next cycle.
- R3: In run, fb_high held for T_OL_WIN ticks raises clamp_rel. Dropping fb_high lowers clamp_rel in the same cycle and restarts the window from zero.
- R4: While clamp_rel is high, ramp_high held for T_SPIKE ticks enters auto-restart with cause 5 (overload).
- R5: supply_ov_lo together with fb_high and softstart held for T_SPIKE ticks enters auto-restart with cause 3. Without softstart it has no effect.
- R6: supply_ov_hi held for T_OVP_HI ticks enters auto-restart with cause 2. It has no effect while burst is high.
- R7: over_temp held for T_SPIKE ticks enters auto-restart with cause 1.
- R8: supply_uv held for T_UV ticks in run enters auto-restart with cause 4.
- R9: In run, after T_EXT_INH ticks from the start of run, ramp_low forces gate_stop high in the same cycle. Held for T_SPIKE ticks, it enters auto-restart with cause 6. Inside the masking window it has no effect.
- R10: ar_state is high in auto-restart and gate_stop stays high there. Exit happens only after supply_uv has been seen and then supply_on. supply_on alone does not release the state.
- R11: When several faults qualify in the same cycle, the recorded cause follows the priority over-temperature(1) > high overvoltage(2) > soft-start overvoltage(3) > undervoltage(4) > overload(5) > external(6). ar_cause holds its value until the next entry into auto-restart.
- R12: The timers advance once every TICK_DIV clock cycles and clear as soon as their condition drops, so interrupted conditions never add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_high | input | 1 | Feedback above overload level |
| ramp_high | input | 1 | Ramp pin above its upper level |
| ramp_low | input | 1 | Ramp pin pulled under shutdown level |
| supply_ov_lo | input | 1 | Supply above the lower overvoltage level |
| supply_ov_hi | input | 1 | Supply above the upper overvoltage level |
| supply_uv | input | 1 | Supply below the off level |
| supply_on | input | 1 | Supply above the on level |
| over_temp | input | 1 | Die over-temperature |
| softstart | input | 1 | Soft start in progress |
| burst | input | 1 | Burst operation active |
| gate_stop | output | 1 | Holds the power switch off |
| clamp_rel | output | 1 | Releases the ramp pin clamp |
| ar_state | output | 1 | Auto-restart state |
| ar_cause | output | 3 | Fault that caused the latest auto-restart |

## Verification
The bench builds the block with TICK_DIV=2, T_OL_WIN=6, T_SPIKE=3, T_OVP_HI=5, T_UV=8 and T_EXT_INH=4. With these values every qualification window lasts only a few cycles, so the full overload chain, the shutdown mask, and the restart through undervoltage and back to on all run in a short test. A tick divider above one makes the timers count ticks and not clocks, which checks that partial windows are discarded. With all spike-filter faults set to the same length, several faults can qualify in the same cycle, which exercises the cause priority.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_OTP    = 3'd1,
        CAUSE_OVP_HI = 3'd2,
        CAUSE_OVP_SS = 3'd3,
        CAUSE_UV     = 3'd4,
        CAUSE_OLOAD  = 3'd5,
        CAUSE_EXT    = 3'd6
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_AR_LOW,
        ST_AR_HIGH
    } sup_state_e;

    typedef struct packed {
        logic otp;
        logic ovp_hi;
        logic ovp_ss;
        logic uv;
        logic oload;
        logic ext;
    } fault_vec_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Fixed priority, most severe first
    function automatic cause_e pick_cause(input fault_vec_t f);
        if (f.otp)         return CAUSE_OTP;
        else if (f.ovp_hi) return CAUSE_OVP_HI;
        else if (f.ovp_ss) return CAUSE_OVP_SS;
        else if (f.uv)     return CAUSE_UV;
        else if (f.oload)  return CAUSE_OLOAD;
        else if (f.ext)    return CAUSE_EXT;
        else               return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/fsup_tick.sv
module fsup_tick #(
    parameter int unsigned TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst || pcnt == LAST) pcnt <= '0;
        else                     pcnt <= pcnt + 1'b1;
    end

    assign tick = (pcnt == LAST);
endmodule

// File: rtl/fsup_qual.sv
module fsup_qual #(
    parameter int unsigned LIMIT = 30,
    parameter int unsigned CW    = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cond,
    output logic done
);
    localparam logic [CW-1:0] LIM_W = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Saturating tick counter, cleared the moment the condition drops
    always_ff @(posedge clk) begin
        if (rst || !cond)             cnt <= '0;
        else if (tick && cnt != LIM_W) cnt <= cnt + 1'b1;
    end

    assign done = cond && (cnt == LIM_W);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int unsigned TICK_DIV  = 100,
    parameter int unsigned T_OL_WIN  = 20000,
    parameter int unsigned T_SPIKE   = 30,
    parameter int unsigned T_OVP_HI  = 150,
    parameter int unsigned T_UV      = 10030,
    parameter int unsigned T_EXT_INH = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fb_high,
    input  logic       ramp_high,
    input  logic       ramp_low,
    input  logic       supply_ov_lo,
    input  logic       supply_ov_hi,
    input  logic       supply_uv,
    input  logic       supply_on,
    input  logic       over_temp,
    input  logic       softstart,
    input  logic       burst,
    output logic       gate_stop,
    output logic       clamp_rel,
    output logic       ar_state,
    output logic [2:0] ar_cause
);
    localparam int unsigned TMAX = imax(imax(imax(T_OL_WIN, T_SPIKE), imax(T_OVP_HI, T_UV)), T_EXT_INH);
    localparam int unsigned CW   = $clog2(TMAX + 1);

    sup_state_e state;
    cause_e     cause_q;
    fault_vec_t faults;
    logic       tick, in_run;
    logic       ol_win_c, ol_win_d, ol_spk_c, ol_spk_d;
    logic       ovss_c, ovss_d, ovhi_c, ovhi_d;
    logic       otp_c, otp_d, uv_c, uv_d;
    logic       inh_d, ext_now, ext_d;

    fsup_tick #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

    assign in_run   = (state == ST_RUN);
    assign ol_win_c = in_run && fb_high;
    assign ol_spk_c = ol_win_d && ramp_high;
    assign ovss_c   = in_run && supply_ov_lo && fb_high && softstart;
    assign ovhi_c   = in_run && supply_ov_hi && !burst;
    assign otp_c    = in_run && over_temp;
    assign uv_c     = in_run && supply_uv;
    assign ext_now  = inh_d && ramp_low;

    fsup_qual #(.LIMIT(T_OL_WIN),  .CW(CW)) u_ol_win (.clk(clk), .rst(rst), .tick(tick), .cond(ol_win_c), .done(ol_win_d));
    fsup_qual #(.LIMIT(T_SPIKE),   .CW(CW)) u_ol_spk (.clk(clk), .rst(rst), .tick(tick), .cond(ol_spk_c), .done(ol_spk_d));
    fsup_qual #(.LIMIT(T_SPIKE),   .CW(CW)) u_ovss   (.clk(clk), .rst(rst), .tick(tick), .cond(ovss_c),   .done(ovss_d));
    fsup_qual #(.LIMIT(T_OVP_HI),  .CW(CW)) u_ovhi   (.clk(clk), .rst(rst), .tick(tick), .cond(ovhi_c),   .done(ovhi_d));
    fsup_qual #(.LIMIT(T_SPIKE),   .CW(CW)) u_otp    (.clk(clk), .rst(rst), .tick(tick), .cond(otp_c),    .done(otp_d));
    fsup_qual #(.LIMIT(T_UV),      .CW(CW)) u_uv     (.clk(clk), .rst(rst), .tick(tick), .cond(uv_c),     .done(uv_d));
    fsup_qual #(.LIMIT(T_EXT_INH), .CW(CW)) u_inh    (.clk(clk), .rst(rst), .tick(tick), .cond(in_run),   .done(inh_d));
    fsup_qual #(.LIMIT(T_SPIKE),   .CW(CW)) u_ext    (.clk(clk), .rst(rst), .tick(tick), .cond(ext_now),  .done(ext_d));

    always_comb begin
        faults.otp    = otp_d;
        faults.ovp_hi = ovhi_d;
        faults.ovp_ss = ovss_d;
        faults.uv     = uv_d;
        faults.oload  = ol_spk_d;
        faults.ext    = ext_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cause_q <= CAUSE_NONE;
        end else begin
            unique case (state)
                ST_IDLE:    if (supply_on) state <= ST_RUN;
                ST_RUN:     if (|faults) begin
                                state   <= ST_AR_LOW;
                                cause_q <= pick_cause(faults);
                            end
                ST_AR_LOW:  if (supply_uv) state <= ST_AR_HIGH;
                ST_AR_HIGH: if (supply_on) state <= ST_RUN;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    assign gate_stop = !in_run || ext_now;
    assign clamp_rel = ol_win_d;
    assign ar_state  = (state == ST_AR_LOW) || (state == ST_AR_HIGH);
    assign ar_cause  = cause_q;
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
    input logic       clk,
    input logic       rst,
    input logic       fb_high,
    input logic       supply_on,
    input logic       gate_stop,
    input logic       clamp_rel,
    input logic       ar_state,
    input logic [2:0] ar_cause
);
    assert_gate_in_ar_R10: assert property (@(posedge clk) disable iff (rst)
        ar_state |-> gate_stop);

    assert_exit_needs_on_R10: assert property (@(posedge clk) disable iff (rst)
        (ar_state && !supply_on) |=> ar_state);

    assert_clamp_valid_R3: assert property (@(posedge clk) disable iff (rst)
        clamp_rel |-> (fb_high && !ar_state));

    assert_cause_set_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ar_state) |-> (ar_cause != 3'd0));

    assert_cause_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !$rose(ar_state) |-> $stable(ar_cause));
endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
    .clk(clk), .rst(rst), .fb_high(fb_high), .supply_on(supply_on),
    .gate_stop(gate_stop), .clamp_rel(clamp_rel), .ar_state(ar_state), .ar_cause(ar_cause)
);

// File: tb/test_fault_supervisor.sv
`timescale 1ns/100ps
module test_fault_supervisor;
    localparam int DIV = 2, L_OL = 6, L_SP = 3, L_OH = 5, L_UV = 8, L_INH = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic fb_high = 0, ramp_high = 0, ramp_low = 0, supply_ov_lo = 0, supply_ov_hi = 0;
    logic supply_uv = 0, supply_on = 0, over_temp = 0, softstart = 0, burst = 0;
    logic gate_stop, clamp_rel, ar_state;
    logic [2:0] ar_cause;

    int checks = 0, errors = 0, cycles = 0;

    always #2.5 clk = ~clk;

    fault_supervisor #(.TICK_DIV(DIV), .T_OL_WIN(L_OL), .T_SPIKE(L_SP), .T_OVP_HI(L_OH),
                       .T_UV(L_UV), .T_EXT_INH(L_INH)) i_fault_supervisor (
        .clk(clk), .rst(rst), .fb_high(fb_high), .ramp_high(ramp_high), .ramp_low(ramp_low),
        .supply_ov_lo(supply_ov_lo), .supply_ov_hi(supply_ov_hi), .supply_uv(supply_uv),
        .supply_on(supply_on), .over_temp(over_temp), .softstart(softstart), .burst(burst),
        .gate_stop(gate_stop), .clamp_rel(clamp_rel), .ar_state(ar_state), .ar_cause(ar_cause));

    // Behavioural reference: mode 0 idle, 1 run, 2 waiting for low supply, 3 waiting for on
    int m_mode = 0, m_cause = 0, k = 0;
    int n_ol = 0, n_sp = 0, n_ss = 0, n_oh = 0, n_ot = 0, n_uv = 0, n_inh = 0, n_ext = 0;

    function automatic bit m_run();     return m_mode == 1; endfunction
    function automatic bit m_inh_ok();  return m_run() && n_inh >= L_INH; endfunction
    function automatic bit m_ext_on();  return m_inh_ok() && ramp_low; endfunction
    function automatic bit m_clamp();   return m_run() && fb_high && n_ol >= L_OL; endfunction

    function automatic int upd(input int n, input bit c, input bit t, input int lim);
        if (!c) return 0;
        if (t && n < lim) return n + 1;
        return n;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_cause = 0; k = 0;
            n_ol = 0; n_sp = 0; n_ss = 0; n_oh = 0; n_ot = 0; n_uv = 0; n_inh = 0; n_ext = 0;
        end else begin
            bit t, r, c_ol, c_sp, c_ss, c_oh, c_ot, c_uv, c_ext;
            bit f_ot, f_oh, f_ss, f_uv, f_ol, f_ex;
            k = k + 1;
            t = (k % DIV) == 0;
            r = m_run();
            c_ol = r && fb_high;
            c_sp = m_clamp() && ramp_high;
            c_ss = r && supply_ov_lo && fb_high && softstart;
            c_oh = r && supply_ov_hi && !burst;
            c_ot = r && over_temp;
            c_uv = r && supply_uv;
            c_ext = m_ext_on();
            f_ot = c_ot && n_ot >= L_SP;  f_oh = c_oh && n_oh >= L_OH;
            f_ss = c_ss && n_ss >= L_SP;  f_uv = c_uv && n_uv >= L_UV;
            f_ol = c_sp && n_sp >= L_SP;  f_ex = c_ext && n_ext >= L_SP;
            n_ol = upd(n_ol, c_ol, t, L_OL);  n_sp = upd(n_sp, c_sp, t, L_SP);
            n_ss = upd(n_ss, c_ss, t, L_SP);  n_oh = upd(n_oh, c_oh, t, L_OH);
            n_ot = upd(n_ot, c_ot, t, L_SP);  n_uv = upd(n_uv, c_uv, t, L_UV);
            n_inh = upd(n_inh, r, t, L_INH);  n_ext = upd(n_ext, c_ext, t, L_SP);
            case (m_mode)
                0: if (supply_on) m_mode = 1;
                1: if (f_ot || f_oh || f_ss || f_uv || f_ol || f_ex) begin
                       m_mode = 2;
                       m_cause = f_ot ? 1 : f_oh ? 2 : f_ss ? 3 : f_uv ? 4 : f_ol ? 5 : 6;
                   end
                2: if (supply_uv) m_mode = 3;
                default: if (supply_on) m_mode = 1;
            endcase
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 R9 R10 gate_stop", gate_stop, (!m_run() || m_ext_on()) ? 1 : 0);
            chk("R3 clamp_rel", clamp_rel, m_clamp() ? 1 : 0);
            chk("R10 ar_state", ar_state, (m_mode >= 2) ? 1 : 0);
            chk("R11 ar_cause", ar_cause, m_cause);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic restart();
        fb_high = 0; ramp_high = 0; ramp_low = 0; supply_ov_lo = 0; supply_ov_hi = 0;
        over_temp = 0; softstart = 0; burst = 0;
        supply_uv = 1; step(1);
        supply_uv = 0; supply_on = 1; step(1);
        supply_on = 0; step(1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog expired: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        step(3);
        chk("R1 gate_stop in reset", gate_stop, 1);
        chk("R1 clamp_rel in reset", clamp_rel, 0);
        chk("R1 ar_state in reset", ar_state, 0);
        chk("R1 ar_cause in reset", ar_cause, 0);
        rst = 0; step(2);
        chk("R2 idle keeps gate off", gate_stop, 1);
        supply_on = 1; step(1); supply_on = 0;
        chk("R2 run after supply_on", gate_stop, 0);

        // R9: masked right after start
        ramp_low = 1; step(4);
        chk("R9 ramp_low masked", gate_stop, 0);
        ramp_low = 0; step(10);
        ramp_low = 1; step(1);
        chk("R9 immediate gate stop", gate_stop, 1);
        step(2); ramp_low = 0; step(1);
        chk("R9 short pulse no restart", ar_state, 0);
        chk("R9 gate resumes", gate_stop, 0);

        // R3: window and clearing
        fb_high = 1; step(8);
        chk("R3 window not yet", clamp_rel, 0);
        step(8);
        chk("R3 clamp released", clamp_rel, 1);
        fb_high = 0; step(1);
        chk("R3 clamp re-engaged", clamp_rel, 0);
        fb_high = 1; step(8);
        chk("R3 window restarted", clamp_rel, 0);
        step(8);
        // R4: second stage
        ramp_high = 1; step(1);
        chk("R4 spike filter", ar_state, 0);
        step(12);
        chk("R4 overload restart", ar_state, 1);
        chk("R4 overload cause", ar_cause, 5);
        fb_high = 0; ramp_high = 0;

        // R10: release only after low then on
        step(5);
        chk("R10 gate off in restart", gate_stop, 1);
        supply_on = 1; step(3);
        chk("R10 on alone ignored", ar_state, 1);
        supply_on = 0; supply_uv = 1; step(1); supply_uv = 0; step(3);
        chk("R10 waits for on", ar_state, 1);
        supply_on = 1; step(1); supply_on = 0;
        chk("R10 restarted", ar_state, 0);
        chk("R11 cause kept after exit", ar_cause, 5);

        // R5
        supply_ov_lo = 1; fb_high = 1; step(10);
        chk("R5 no effect without soft start", ar_state, 0);
        softstart = 1; step(10);
        chk("R5 soft-start overvoltage", ar_cause, 3);
        restart();

        // R6
        burst = 1; supply_ov_hi = 1; step(20);
        chk("R6 ignored in burst", ar_state, 0);
        burst = 0; step(14);
        chk("R6 high overvoltage", ar_cause, 2);
        restart();

        // R12 and R7
        over_temp = 1; step(5);
        chk("R12 partial window", ar_state, 0);
        over_temp = 0; step(1); over_temp = 1; step(5);
        chk("R12 timer cleared", ar_state, 0);
        step(4);
        chk("R7 over-temperature", ar_cause, 1);
        restart();

        // R8
        supply_uv = 1; step(14);
        chk("R8 under window", ar_state, 0);
        step(6);
        chk("R8 undervoltage", ar_cause, 4);
        restart();

        // R11: simultaneous qualification
        step(12);
        over_temp = 1; supply_ov_lo = 1; fb_high = 1; softstart = 1; ramp_low = 1; step(10);
        chk("R11 priority over-temp first", ar_cause, 1);
        restart();
        step(12);
        supply_ov_lo = 1; fb_high = 1; softstart = 1; ramp_low = 1; step(10);
        chk("R11 priority overvoltage over external", ar_cause, 3);
        restart();
        step(12);
        ramp_low = 1; step(10);
        chk("R9 external restart", ar_cause, 6);
        restart();
        step(4);
        finish_run();
    end
endmodule